// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block sits beside a small 8-bit processor core. It decides which of five interrupt request lines the core should service next. The five sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port, which raises a single request for either receive or transmit. Software controls the block through two 8-bit configuration registers, a mask register and a level register. Both are written and read over a simple select/write-enable port.

Each cycle the controller looks at the requests that are unmasked and assigns each one to a high or low level. It then compares that level against two in-service flags, one per level. The winner's vector address and a request strobe appear in the same cycle. A low-level handler can be preempted only by a high-level request. A high-level handler cannot be preempted at all. When the core takes the interrupt it pulses the acknowledge input, which marks the winner's level as in service. A return-from-interrupt pulse releases the highest level that is in service. An ordinary subroutine return does not touch the controller.

Top module: `intc2`

## Requirements
- R1: After reset the mask register, the level register and both in-service flags are zero, and `irq_o` is 0 whatever the requests are.
- R2: With `cfg_sel`=0 the mask register is selected. Bit 7 is the global enable. Bits 4..0 enable serial, timer 1, external 1, timer 0 and external 0, from bit 4 down to bit 0. Bits 6:5 are reserved: writes to them are ignored and they read 0. With `cfg_sel`=1 the level register is selected. It uses the same bit positions 4..0, and bits 7:5 read 0. Writes take effect at the clock edge when `cfg_we`=1.
- R3: While the global enable is 0, `irq_o` stays 0 for any requests and per-source enables.
- R4: A request whose per-source enable bit is 0 is never granted.
- R5: Within one level, the lowest `req_i` index wins. Index 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1 and 4 is serial. `vec_o` = 0x0003 + 8 × index, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R6: A level-register bit of 1 makes its source high level. When high-level and low-level requests are present together, a high-level one wins.
- R7: While the low in-service flag is set, low-level requests are not granted, but high-level requests are.
- R8: While the high in-service flag is set, no request is granted.
- R9: `ack_i` in a cycle with `irq_o`=1 sets the in-service flag of the winner's level at that edge. `ack_i` with `irq_o`=0 has no effect.
- R10: `reti_i` clears the high in-service flag if it is set, otherwise the low one. The other flag is left unchanged.
- R11: `irq_o` and `vec_o` follow the current requests and state in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Request flags, index 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0 selects mask register, 1 selects level register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| ack_i | input | 1 | Core takes the offered interrupt |
| reti_i | input | 1 | Return-from-interrupt pulse |
| irq_o | output | 1 | Interrupt request strobe |
| vec_o | output | 16 | Vector address of the winner |

## Verification
The hardest state to reach from the ports is both in-service flags set at once. This is the nested case, where a low-level handler has been preempted. Reaching it also requires checking that one return pulse frees only the high level. The stimulus first acknowledges a low-level request. It then moves a source to high level through the level register while the low handler is still in service, and acknowledges that request too. From there, pending low-level and high-level requests show which flag each return pulse released. A behavioural reference model is compared with the outputs on every cycle of this sequence.

// File: rtl/intc2.sv
module intc2 #(
  parameter int NSRC     = 5,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req_i,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic            gie, is_lo, is_hi, is_lo_n, is_hi_n;
  logic [NSRC-1:0] ien, ipri;
  logic [IDX_W-1:0] idx;

  wire [NSRC-1:0] live   = req_i & ien & {NSRC{gie}};
  wire [NSRC-1:0] hi_c   = live & ipri & {NSRC{~is_hi}};
  wire [NSRC-1:0] lo_c   = live & ~ipri & {NSRC{~(is_hi | is_lo)}};
  wire            use_hi = |hi_c;
  wire [NSRC-1:0] pick   = use_hi ? hi_c : lo_c;
  wire            grant  = ack_i & irq_o;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pick[i]) idx = IDX_W'(i);
  end

  assign irq_o     = |pick;
  assign vec_o     = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(idx);
  assign cfg_rdata = cfg_sel ? {{(8-NSRC){1'b0}}, ipri}
                             : {gie, {(7-NSRC){1'b0}}, ien};

  always_comb begin
    is_hi_n = is_hi;
    is_lo_n = is_lo;
    if (reti_i) begin
      if (is_hi) is_hi_n = 1'b0;
      else       is_lo_n = 1'b0;
    end
    if (grant) begin
      if (use_hi) is_hi_n = 1'b1;
      else        is_lo_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie   <= 1'b0;
      ien   <= '0;
      ipri  <= '0;
      is_lo <= 1'b0;
      is_hi <= 1'b0;
    end else begin
      is_lo <= is_lo_n;
      is_hi <= is_hi_n;
      if (cfg_we && !cfg_sel) begin
        gie <= cfg_wdata[7];
        ien <= cfg_wdata[NSRC-1:0];
      end
      if (cfg_we && cfg_sel) ipri <= cfg_wdata[NSRC-1:0];
    end
  end

  assert_gie_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_o);
  assert_hi_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_hi |-> !irq_o);
  assert_lo_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_lo && irq_o) |-> (|(req_i & ien & ipri)));
  assert_enabled_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_i[idx] && ien[idx]));
  assert_ack_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !reti_i) |=> (is_hi || is_lo));
  assert_reti_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && is_hi && !ack_i) |=> (!is_hi && is_lo == $past(is_lo)));
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!is_hi && !is_lo && !gie && ien == '0 && ipri == '0));
endmodule

// File: tb/tb_intc2.sv
module tb_intc2;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] req_i = '0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0, ack_i = 1'b0, reti_i = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       irq_o;
  logic [15:0] vec_o;

  int checks = 0, fails = 0;
  logic [7:0] m_mask = '0, m_lvl = '0;
  bit m_lo = 0, m_hi = 0;
  bit e_irq;
  int e_win;

  intc2 dut (.clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .vec_o(vec_o));

  always #2 clk = ~clk;

  task automatic expect_now();
    e_irq = 0; e_win = 0;
    if (rst_n && m_mask[7] && !m_hi) begin
      for (int s = 0; s < 5; s++)
        if (!e_irq && req_i[s] && m_mask[s] && m_lvl[s]) begin e_irq = 1; e_win = s; end
      if (!e_irq && !m_lo)
        for (int s = 0; s < 5; s++)
          if (!e_irq && req_i[s] && m_mask[s] && !m_lvl[s]) begin e_irq = 1; e_win = s; end
    end
  endtask

  task automatic step(input string tag);
    logic [7:0] e_rd;
    #1;
    expect_now();
    e_rd = cfg_sel ? {3'b0, m_lvl[4:0]} : {m_mask[7], 2'b0, m_mask[4:0]};
    checks++;
    if (irq_o !== e_irq) begin
      fails++; $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, e_irq);
    end
    if (e_irq) begin
      checks++;
      if (vec_o !== 16'(3 + 8 * e_win)) begin
        fails++; $display("FAIL %s vec_o actual=%h expected=%h", tag, vec_o, 16'(3 + 8 * e_win));
      end
    end
    checks++;
    if (cfg_rdata !== e_rd) begin
      fails++; $display("FAIL %s cfg_rdata actual=%h expected=%h", tag, cfg_rdata, e_rd);
    end
    @(posedge clk);
    if (!rst_n) begin
      m_mask = '0; m_lvl = '0; m_lo = 0; m_hi = 0;
    end else begin
      if (reti_i) begin
        if (m_hi) m_hi = 0; else m_lo = 0;
      end
      if (ack_i && e_irq) begin
        if (m_lvl[e_win]) m_hi = 1; else m_lo = 1;
      end
      if (cfg_we && !cfg_sel) m_mask = cfg_wdata & 8'h9F;
      if (cfg_we && cfg_sel)  m_lvl  = cfg_wdata & 8'h1F;
    end
    @(negedge clk);
    cfg_we = 0; ack_i = 0; reti_i = 0;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d, input string tag);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    step(tag);
    cfg_sel = sel;
    step(tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    req_i = 5'h1F;
    step("R1 in reset");
    rst_n = 1;
    cfg_sel = 0; step("R1 mask after reset");
    cfg_sel = 1; step("R1 level after reset");
    wr(0, 8'hFF, "R2 mask reserved bits");
    wr(1, 8'hFF, "R2 level upper bits");
    wr(1, 8'h00, "R2 level clear");
    wr(0, 8'h1F, "R3 global off");
    req_i = 5'h01; step("R3 single request");
    wr(0, 8'h9A, "R4 partial mask");
    req_i = 5'h05; step("R4 masked sources");
    req_i = 5'h1F; step("R5 timer0 wins");
    wr(0, 8'h9F, "R5 all enabled");
    req_i = 5'h1C; step("R5 ext1 wins");
    req_i = 5'h18; step("R5 timer1 wins");
    req_i = 5'h10; step("R5 serial vector");
    wr(1, 8'h10, "R6 serial high");
    req_i = 5'h11; step("R6 high beats low");
    wr(1, 8'h00, "R6 back to low");
    req_i = 5'h00; ack_i = 1; step("R9 ack without irq");
    req_i = 5'h02; step("R9 no flag set");
    req_i = 5'h08; ack_i = 1; step("R9 ack low");
    req_i = 5'h01; step("R7 low blocked");
    wr(1, 8'h01, "R7 ext0 high");
    req_i = 5'h01; step("R7 high preempts");
    ack_i = 1; step("R9 ack high");
    req_i = 5'h1F; step("R8 all blocked");
    step("R8 still blocked");
    reti_i = 1; step("R10 reti releases high");
    req_i = 5'h01; step("R10 high free again");
    req_i = 5'h02; step("R10 low still held");
    reti_i = 1; step("R10 reti releases low");
    step("R10 low free");
    reti_i = 1; step("R10 reti idle");
    req_i = 5'h03; ack_i = 1; reti_i = 1; step("R11 ack and reti together");
    req_i = 5'h00; step("R11 no requests");
    req_i = 5'h03; step("R11 after combined");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule